// File: doc/BRIEF.md
# Configurable SPI Master Shift Engine

This block is the serial core of a single-lane SPI master. It takes words from a transmit FIFO through a valid/pop interface and shifts them out on MOSI. At the same time it assembles the bits it samples into a word, which it hands to a receive FIFO through a push strobe. A reload value sets the serial clock rate. Static control inputs select the word length, clock polarity, sampling phase, bit order, idle level of the data line, internal loopback, and separate disables for the transmit and receive paths. The FIFOs, register access, chip-select generation and error bookkeeping live outside the block.

A single state machine sequences each word. `S_IDLE` waits for the transmit FIFO. `S_IDLE -> S_PHASE_A` happens when a word is popped. `S_PHASE_A` is the half period with SCLK at its idle level. `S_PHASE_A -> S_PHASE_B` happens on a divider tick and makes the leading SCLK edge. `S_PHASE_B` is the half period with SCLK at its active level. `S_PHASE_B -> S_PHASE_A` happens on a tick when more bits remain (the trailing edge). `S_PHASE_B -> S_IDLE` happens on the tick of the final bit, and it also pushes the received word. The transmit-drained event fires as soon as a pop leaves the FIFO empty, while that word is still on the wire. The busy flag stays up until the final bit has completed.

Top module: `spi_shift_engine`

## Requirements
- R1: Each SCLK half period lasts exactly baud_reload+1 clock cycles, so a full SCLK period is 2*(baud_reload+1) cycles; a reload of 0 gives the fastest rate.
- R2: A word has word_len_m1+1 bits, using SCLK pulses equal in number to its bits; rxq_data holds the received bits in positions 0..word_len_m1 and zeros above; lengths 2 to 8, 16 and 32 are supported.
- R3: With early_sample=1 (clock phase 0), the first bit is on MOSI before the leading edge, MISO is sampled on leading edges, and MOSI changes on trailing edges. With early_sample=0 (clock phase 1), MOSI changes on leading edges and MISO is sampled on trailing edges.
- R4: SCLK rests at clock_pol whenever no word is in progress, and the leading edge of every bit moves it away from clock_pol.
- R5: MOSI equals idle_level whenever no word is in progress.
- R6: With msb_first=1, bit word_len_m1 is sent and received first. With msb_first=0, bit 0 is sent and received first.
- R7: With loop_en=1, the receiver samples the engine's own MOSI and MISO has no effect on rxq_data.
- R8: With tx_disable=1, MOSI holds idle_level for the whole word, and the word is still popped from the transmit FIFO.
- R9: With rx_disable=1, rxq_push stays low for the word.
- R10: Each popped word with the receiver on gives exactly one rxq_push, 2*(word_len_m1+1)*(baud_reload+1)+1 cycles after the pop cycle.
- R11: tx_drained pulses in the cycle after a pop that leaves txq_valid low. busy stays high from the first pop until the last word's final bit has completed, and is low in the cycle of the last push.
- R12: After reset the engine is idle: busy, txq_pop and rxq_push are low, SCLK equals clock_pol and MOSI equals idle_level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_reload | input | 16 | Half-period reload; half period = value+1 cycles |
| word_len_m1 | input | 5 | Word length minus one |
| clock_pol | input | 1 | SCLK idle level |
| early_sample | input | 1 | 1: sample on leading edge (clock phase 0); 0: sample on trailing edge |
| msb_first | input | 1 | 1: most significant bit first |
| idle_level | input | 1 | MOSI level outside words and when transmit is disabled |
| loop_en | input | 1 | Route MOSI internally to the receiver |
| tx_disable | input | 1 | Hold MOSI at idle_level during words |
| rx_disable | input | 1 | Suppress pushes of received words |
| txq_valid | input | 1 | Transmit FIFO holds at least one word |
| txq_data | input | 32 | Head word of the transmit FIFO |
| txq_pop | output | 1 | Removes the head word from the transmit FIFO |
| rxq_push | output | 1 | Received word valid on rxq_data |
| rxq_data | output | 32 | Received word |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| busy | output | 1 | Word in progress or pending |
| tx_drained | output | 1 | One-cycle pulse after the FIFO empties |

## Verification
The assertions assume that all mode inputs and the baud reload stay constant while busy is high. They also assume that the transmit FIFO updates txq_valid in the cycle after a pop. The stimulus therefore changes configuration only when the engine is idle and the FIFO is empty, and its FIFO model updates its count on the clock edge that takes the pop. A slave model in the bench drives MISO and captures MOSI on the correct edges for each phase. It also measures the spacing of SCLK edges, so the sweep over polarity, phase, order, length and rate checks the waveform itself and not only the words.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

    typedef enum logic [1:0] {
        S_IDLE    = 2'd0,
        S_PHASE_A = 2'd1,
        S_PHASE_B = 2'd2
    } eng_state_t;

endpackage

// File: rtl/spi_eng_baud.sv
module spi_eng_baud #(
    parameter int BAUD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [BAUD_W-1:0] reload,
    output logic              tick
);

    logic [BAUD_W-1:0] cnt_q;

    assign tick = run && (cnt_q == reload);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R1: with a nonzero reload, two ticks are never adjacent
    assert_tick_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (reload != '0)) |=> !tick);

endmodule

// File: rtl/spi_eng_txbit.sv
module spi_eng_txbit #(
    parameter int DATA_W = 32,
    localparam int LEN_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] word,
    input  logic [LEN_W-1:0]  last_idx,
    input  logic              msb_first,
    input  logic              early,
    input  logic              tx_off,
    input  logic              idle_level,
    input  logic              lead_tick,
    input  logic              trail_tick,
    input  logic [LEN_W-1:0]  bit_idx,
    input  logic              last_bit,
    output logic              bit_out
);

    logic [DATA_W-1:0] word_q;

    function automatic logic pick(input logic [DATA_W-1:0] w,
                                  input logic [LEN_W-1:0]  k,
                                  input logic [LEN_W-1:0]  top,
                                  input logic              msb,
                                  input logic              off,
                                  input logic              idl);
        logic [LEN_W-1:0] slot;
        slot = msb ? (top - k) : k;
        return off ? idl : w[slot];
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q  <= '0;
            bit_out <= 1'b0;
        end else if (load) begin
            word_q  <= word;
            bit_out <= early ? pick(word, {LEN_W{1'b0}}, last_idx, msb_first, tx_off, idle_level)
                             : idle_level;
        end else if (lead_tick && !early) begin
            bit_out <= pick(word_q, bit_idx, last_idx, msb_first, tx_off, idle_level);
        end else if (trail_tick && early) begin
            bit_out <= last_bit ? idle_level
                                : pick(word_q, bit_idx + 1'b1, last_idx, msb_first, tx_off, idle_level);
        end
    end

endmodule

// File: rtl/spi_eng_rxacc.sv
module spi_eng_rxacc #(
    parameter int DATA_W = 32,
    localparam int LEN_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              sample,
    input  logic              din,
    input  logic [LEN_W-1:0]  bit_idx,
    input  logic [LEN_W-1:0]  last_idx,
    input  logic              msb_first,
    input  logic              finish,
    input  logic              rx_off,
    output logic [DATA_W-1:0] acc_q,
    output logic              push_q
);

    logic [LEN_W-1:0] slot;

    assign slot = msb_first ? (last_idx - bit_idx) : bit_idx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q  <= '0;
            push_q <= 1'b0;
        end else begin
            push_q <= finish && !rx_off;
            if (clear) begin
                acc_q <= '0;
            end else if (sample) begin
                acc_q[slot] <= din;
            end
        end
    end

    // R10: one word yields a single push, never two in a row
    assert_single_push_R10: assert property (@(posedge clk) disable iff (!rst_n)
        push_q |=> !push_q);

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
    import spi_eng_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int BAUD_W = 16,
    localparam int LEN_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BAUD_W-1:0] baud_reload,
    input  logic [LEN_W-1:0]  word_len_m1,
    input  logic              clock_pol,
    input  logic              early_sample,
    input  logic              msb_first,
    input  logic              idle_level,
    input  logic              loop_en,
    input  logic              tx_disable,
    input  logic              rx_disable,
    input  logic              txq_valid,
    input  logic [DATA_W-1:0] txq_data,
    output logic              txq_pop,
    output logic              rxq_push,
    output logic [DATA_W-1:0] rxq_data,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic              busy,
    output logic              tx_drained
);

    eng_state_t       state_q, state_d;
    logic [LEN_W-1:0] bit_q;
    logic             pop_q;
    logic             tick, start, lead_tick, trail_tick, last_bit;
    logic             word_end, sample_now, tx_bit, rx_din;

    assign start      = (state_q == S_IDLE) && txq_valid;
    assign lead_tick  = (state_q == S_PHASE_A) && tick;
    assign trail_tick = (state_q == S_PHASE_B) && tick;
    assign last_bit   = (bit_q == word_len_m1);
    assign word_end   = trail_tick && last_bit;
    assign sample_now = early_sample ? lead_tick : trail_tick;
    assign rx_din     = loop_en ? mosi : miso;

    always_comb begin : next_state
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (txq_valid) state_d = S_PHASE_A;
            S_PHASE_A: if (tick)      state_d = S_PHASE_B;
            S_PHASE_B: if (tick)      state_d = last_bit ? S_IDLE : S_PHASE_A;
            default:                  state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin : state_reg
        if (!rst_n) begin
            state_q <= S_IDLE;
            bit_q   <= '0;
            pop_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            pop_q   <= start;
            if (start) begin
                bit_q <= '0;
            end else if (trail_tick && !last_bit) begin
                bit_q <= bit_q + 1'b1;
            end
        end
    end

    always_comb begin : drive_outputs
        txq_pop    = start;
        sclk       = clock_pol ^ (state_q == S_PHASE_B);
        mosi       = (state_q == S_IDLE) ? idle_level : tx_bit;
        busy       = (state_q != S_IDLE) || txq_valid;
        tx_drained = pop_q && !txq_valid;
    end

    spi_eng_baud #(.BAUD_W(BAUD_W)) u_baud (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (state_q != S_IDLE),
        .reload (baud_reload),
        .tick   (tick)
    );

    spi_eng_txbit #(.DATA_W(DATA_W)) u_txbit (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (start),
        .word       (txq_data),
        .last_idx   (word_len_m1),
        .msb_first  (msb_first),
        .early      (early_sample),
        .tx_off     (tx_disable),
        .idle_level (idle_level),
        .lead_tick  (lead_tick),
        .trail_tick (trail_tick),
        .bit_idx    (bit_q),
        .last_bit   (last_bit),
        .bit_out    (tx_bit)
    );

    spi_eng_rxacc #(.DATA_W(DATA_W)) u_rxacc (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (start),
        .sample    (sample_now),
        .din       (rx_din),
        .bit_idx   (bit_q),
        .last_idx  (word_len_m1),
        .msb_first (msb_first),
        .finish    (word_end),
        .rx_off    (rx_disable),
        .acc_q     (rxq_data),
        .push_q    (rxq_push)
    );

    // R4: clock rests at its polarity level when nothing is pending
    assert_sclk_rest_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sclk == clock_pol));

    // R5: data line rests at the idle level when nothing is pending
    assert_mosi_rest_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (mosi == idle_level));

    // R8: a disabled transmitter never shows data on the line
    assert_tx_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_disable |-> (mosi == idle_level));

    // R9: no push for a word shifted with the receiver disabled
    assert_rx_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rxq_push |-> !$past(rx_disable));

    // R10: a push only closes a word that kept the engine busy
    assert_push_after_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rxq_push |-> $past(busy));

    // R11: a popped word keeps busy up in the following cycle
    assert_pop_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        txq_pop |=> busy);

    // R11: the drained event arrives while the last word is still shifting
    assert_drained_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        tx_drained |-> busy);

    // R2: format inputs are held while a word is in flight (input contract)
    assert_cfg_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(word_len_m1) && $stable(early_sample) &&
                                   $stable(msb_first) && $stable(baud_reload)));

endmodule

// File: tb/sim_spi_shift_engine.sv
module sim_spi_shift_engine;

    localparam int DATA_W = 32;
    localparam int BAUD_W = 16;
    localparam int LEN_W  = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [BAUD_W-1:0] baud = '0;
    logic [LEN_W-1:0]  wlen = 5'd7;
    logic pol = 1'b0, early = 1'b1, msb = 1'b1, idl = 1'b0;
    logic loop = 1'b0, txoff = 1'b0, rxoff = 1'b0;

    logic              txq_valid, txq_pop, rxq_push, sclk, mosi, busy, tx_drained;
    logic [DATA_W-1:0] txq_data, rxq_data;
    logic              miso_r = 1'b0;

    // transmit FIFO model
    logic [DATA_W-1:0] fmem [0:3];
    logic [2:0]        fcnt = '0;
    logic [1:0]        fhead = '0;
    logic              f_wr = 1'b0;
    logic [DATA_W-1:0] f_wdata = '0;

    assign txq_valid = (fcnt != 3'd0);
    assign txq_data  = fmem[fhead];

    always @(posedge clk) begin
        if (f_wr) fmem[fhead + fcnt[1:0]] <= f_wdata;
        if (txq_pop) fhead <= fhead + 2'd1;
        fcnt <= fcnt + {2'b0, f_wr} - {2'b0, txq_pop};
    end

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    spi_shift_engine u0 (
        .clk(clk), .rst_n(rst_n), .baud_reload(baud), .word_len_m1(wlen),
        .clock_pol(pol), .early_sample(early), .msb_first(msb), .idle_level(idl),
        .loop_en(loop), .tx_disable(txoff), .rx_disable(rxoff),
        .txq_valid(txq_valid), .txq_data(txq_data), .txq_pop(txq_pop),
        .rxq_push(rxq_push), .rxq_data(rxq_data), .sclk(sclk), .mosi(mosi),
        .miso(miso_r), .busy(busy), .tx_drained(tx_drained)
    );

    // slave model and monitors
    logic [DATA_W-1:0] sl_word = '0;
    logic [DATA_W-1:0] seen = '0, word_seen = '0, last_rx = '0;
    logic sclk_prev = 1'b0, mosi_prev = 1'b0;
    int e = 0, k = 0, gap = 0;
    int gap_bad = 0, idle_bad = 0, words_done = 0;
    int pop_cnt = 0, push_cnt = 0, drain_cnt = 0;
    int last_pop = 0, last_push = 0, last_drain = 0;

    function automatic int slot_of(input int kk);
        int n;
        n = int'(wlen) + 1;
        return msb ? (n - 1 - kk) : kk;
    endfunction

    function automatic logic sbit(input int kk);
        if (kk >= int'(wlen) + 1) return 1'b0;
        return sl_word[slot_of(kk)];
    endfunction

    always @(negedge clk) begin
        if (!rst_n) begin
            e = 0; k = 0; gap = 0; seen = '0;
        end else begin
            if (txq_pop)    begin pop_cnt++;  last_pop = cyc; end
            if (rxq_push)   begin push_cnt++; last_push = cyc; last_rx = rxq_data; end
            if (tx_drained) begin drain_cnt++; last_drain = cyc; end
            if (!busy && e == 0 && (sclk !== pol || mosi !== idl)) idle_bad++;
            gap++;
            if (sclk !== sclk_prev && (busy || e != 0)) begin
                e++;
                if (e > 1 && gap != int'(baud) + 1) gap_bad++;
                gap = 0;
                if ((e % 2) == 1 && sclk !== ~pol) gap_bad++;
                if (early) begin
                    if ((e % 2) == 1) seen[slot_of(k)] = mosi_prev;
                    else begin k++; miso_r = sbit(k); end
                end else begin
                    if ((e % 2) == 1) miso_r = sbit(k);
                    else begin seen[slot_of(k)] = mosi_prev; k++; end
                end
                if (e == 2 * (int'(wlen) + 1)) begin
                    e = 0; k = 0; word_seen = seen; seen = '0; words_done++;
                end
            end
            if (e == 0) miso_r = sbit(0);
        end
        sclk_prev = sclk;
        mosi_prev = mosi;
    end

    int checks = 0, errors = 0;
    bit finished = 1'b0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick_sample;
        @(negedge clk);
        #1;
    endtask

    task automatic do_word(input logic [31:0] txw, input logic [31:0] slw);
        int p0, w0, g0, i0, q0, n;
        logic [31:0] mask, etx, erx;
        n = int'(wlen) + 1;
        mask = (n >= 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 32'h1);
        sl_word = slw;
        p0 = push_cnt; w0 = words_done; g0 = gap_bad; i0 = idle_bad; q0 = pop_cnt;
        tick_sample;
        f_wr = 1'b1; f_wdata = txw;
        tick_sample;
        f_wr = 1'b0;
        for (int i = 0; i < 4000 && words_done == w0; i++) tick_sample;
        repeat (2) tick_sample;
        etx = txoff ? (idl ? mask : 32'h0) : (txw & mask);
        erx = loop ? etx : (slw & mask);
        chk("R3,R6 bits seen on MOSI", word_seen, etx);
        chk("R8 word popped once", 32'(pop_cnt - q0), 32'd1);
        if (rxoff) begin
            chk("R9 no push with receiver off", 32'(push_cnt - p0), 32'd0);
        end else begin
            chk("R2,R3,R7 received word", last_rx, erx);
            chk("R10 one push per word", 32'(push_cnt - p0), 32'd1);
            chk("R10 push latency", 32'(last_push - last_pop), 32'(2 * n * (int'(baud) + 1) + 1));
        end
        chk("R1,R4 edge spacing and direction", 32'(gap_bad - g0), 32'd0);
        chk("R4,R5 idle levels", 32'(idle_bad - i0), 32'd0);
    endtask

    function automatic logic [LEN_W-1:0] len_of(input int i);
        case (i)
            0: return 5'd1;
            1: return 5'd2;
            2: return 5'd4;
            3: return 5'd7;
            4: return 5'd15;
            default: return 5'd31;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog R10 actual=hung expected=done");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int seed;
        int d0, p0, lowb;
        seed = 1;
        repeat (3) tick_sample;
        // R12 during and after reset
        chk("R12 busy in reset", 32'(busy), 32'd0);
        chk("R12 push in reset", 32'(rxq_push), 32'd0);
        rst_n = 1'b1;
        repeat (2) tick_sample;
        chk("R12 busy idle", 32'(busy), 32'd0);
        chk("R12 pop idle", 32'(txq_pop), 32'd0);
        chk("R12 sclk idle", 32'(sclk), 32'(pol));
        chk("R12 mosi idle", 32'(mosi), 32'(idl));

        // near-exhaustive sweep of mode, order, length and rate
        for (int p = 0; p < 2; p++)
            for (int h = 0; h < 2; h++)
                for (int m = 0; m < 2; m++)
                    for (int li = 0; li < 6; li++)
                        for (int bi = 0; bi < 2; bi++) begin
                            pol = p[0]; early = h[0]; msb = m[0];
                            idl = p[0] ^ m[0];
                            wlen = len_of(li);
                            baud = 16'(bi * 2);
                            loop = 1'b0; txoff = 1'b0; rxoff = 1'b0;
                            seed++;
                            do_word(32'hA5C3_1E6B ^ (32'(seed) * 32'h9E37_79B1),
                                    32'h3C96_F00D ^ (32'(seed) * 32'h0101_7F45));
                        end

        // R7 loopback ignores MISO
        pol = 1'b0; early = 1'b1; msb = 1'b1; idl = 1'b0; wlen = 5'd7; baud = 16'd1;
        loop = 1'b1;
        do_word(32'h0000_00B6, 32'h0000_0049);
        early = 1'b0; msb = 1'b0; wlen = 5'd15;
        do_word(32'h0000_D1E5, 32'h0000_2E1A);

        // R8 transmitter off: MOSI held at idle, looped word equals idle fill
        idl = 1'b1; txoff = 1'b1;
        do_word(32'h0000_0000, 32'h0000_1234);
        loop = 1'b0; idl = 1'b0; wlen = 5'd7;
        do_word(32'h0000_00FF, 32'h0000_005A);
        txoff = 1'b0;

        // R9 receiver off
        rxoff = 1'b1;
        do_word(32'h0000_0081, 32'h0000_0042);
        rxoff = 1'b0;

        // R11 drained event and continuous busy over two queued words
        wlen = 5'd7; baud = 16'd1; early = 1'b1; msb = 1'b1;
        sl_word = 32'h0000_0077;
        d0 = drain_cnt; p0 = push_cnt; lowb = 0;
        tick_sample;
        f_wr = 1'b1; f_wdata = 32'h0000_0011;
        tick_sample;
        f_wdata = 32'h0000_0022;
        tick_sample;
        f_wr = 1'b0;
        for (int i = 0; i < 4000 && push_cnt < p0 + 2; i++) begin
            if (!busy) lowb++;
            tick_sample;
        end
        chk("R11 busy low in last push cycle", 32'(busy), 32'd0);
        chk("R11 busy held across queued words", 32'(lowb), 32'd0);
        chk("R11 single drained event", 32'(drain_cnt - d0), 32'd1);
        chk("R11 drained one cycle after last pop", 32'(last_drain - last_pop), 32'd1);
        chk("R10 both words pushed", 32'(push_cnt - p0), 32'd2);
        chk("R2 second word received", last_rx, 32'h0000_0077);

        finished = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule